// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches a bank of synchronous input lines and turns selected activity on them into sticky per-line event flags. Every line is first passed through a two-stage synchronizer and a programmable deglitch filter. It then goes to a detector that fires on a chosen condition: a high or low level, a rising or falling edge, or either edge. A fired detector sets the line's status flag. Software can also set any flag directly, and it clears flags by writing ones.

Each flag is gated by an interrupt enable to drive one bit of the interrupt vector. A second, independent enable lets the same flag take part in a single combined wakeup request. Configuration, status readback, clearing and software triggering all use a small single-cycle register port. Writes take effect on the clock edge where `reg_we` is high. Reads are combinational from `reg_addr`.

Register map (word addresses on `reg_addr`):

| Address | Contents |
|---|---|
| 0..NLINES-1 | Per-line configuration: bits [2:0] are the trigger code, bits [15:8] are the filter length |
| 16 | Interrupt enable mask |
| 17 | Wakeup enable mask |
| 18 | Status: reads the flags; writing a 1 clears that flag |
| 19 | Software trigger: writing a 1 sets that flag; reads as 0 |

Trigger codes:

| Code | Meaning |
|---|---|
| 0 | High level |
| 1 | Low level |
| 2 | Falling edge |
| 3 | Rising edge |
| 4 | Either edge |
| 5, 6, 7 | Line off |

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every status flag, every interrupt output and the wakeup output are 0, and every line's configuration reads back trigger code 7 (off) and filter length 0.
- R2: With trigger code 3 and filter length N, a 0-to-1 change of a line's pin that is stable during the cycle where it is applied shows up on `irq_o` (with interrupt enable set) 3+N clock edges later, and not one edge earlier; a 1-to-0 change does not set the flag, and a held high level does not set it again after a clear.
- R3: With trigger code 2, a 1-to-0 pin change sets the flag with the same latency as R2, and a 0-to-1 change does not.
- R4: With trigger code 4, both a 0-to-1 and a 1-to-0 pin change set the flag.
- R5: With trigger code 0, the flag is set on every cycle where the filtered level is 1, so a clear written while the level is still high leaves the flag set.
- R6: With trigger code 1, the flag is set while the filtered level is 0.
- R7: With filter length N greater than 0, a new level is accepted only after it has been seen on N consecutive synchronized samples. A pin pulse shorter than N cycles never sets the flag, and a pulse of exactly N cycles does set it. Length 0 bypasses the filter.
- R8: Writing a 1 to a bit of address 18 clears that flag on the same write edge, and writing 0 leaves the flag unchanged.
- R9: Writing a 1 to a bit of address 19 sets that flag on the write edge, even for a line whose trigger code is off.
- R10: `irq_o[i]` is flag i ANDed with interrupt enable i. A flag with its enable cleared is still set and still readable at address 18, and it appears on `irq_o` as soon as the enable is written.
- R11: `wake_o` is 1 exactly when some flag is set whose wakeup enable is also set.
- R12: A line with trigger code 5, 6 or 7 never sets its flag from pin activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NLINES | Raw input lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |
| irq_o | output | NLINES | Per-line interrupt requests |
| wake_o | output | 1 | Combined wakeup request |

## Verification
The hardest cases to reach are the filter boundaries. A pin pulse one cycle shorter than the programmed length must vanish, and one of exactly that length must survive. Because the synchronizer and the filter counter add latency, the bench holds the pin for a counted number of cycles. It then checks the flag on the precise edge that the 3+N latency predicts, and also one edge before it.

The other difficult case is a clear that collides with an active level, which the bench reaches by keeping a level-triggered pin high while writing the clear.

// File: rtl/eil_pkg.sv
package eil_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;

  localparam logic [2:0] TRG_HIGH = 3'd0;
  localparam logic [2:0] TRG_LOW  = 3'd1;
  localparam logic [2:0] TRG_FALL = 3'd2;
  localparam logic [2:0] TRG_RISE = 3'd3;
  localparam logic [2:0] TRG_BOTH = 3'd4;
  localparam logic [2:0] TRG_OFF  = 3'd7;

  localparam logic [ADDR_W-1:0] A_IEN  = 5'd16;
  localparam logic [ADDR_W-1:0] A_WEN  = 5'd17;
  localparam logic [ADDR_W-1:0] A_STAT = 5'd18;
  localparam logic [ADDR_W-1:0] A_SWT  = 5'd19;
endpackage

// File: rtl/eil_filter.sv
module eil_filter #(
  parameter int unsigned FLT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic [FLT_W-1:0] len_i,
  output logic             lvl_o
);
  localparam int unsigned CW = FLT_W + 1;

  logic             s1_q, s2_q, lvl_q, lvl_d;
  logic [FLT_W-1:0] cnt_q, cnt_d;
  logic             bypass;
  logic [CW-1:0]    run_len;

  assign bypass  = (len_i == '0);
  assign run_len = {1'b0, cnt_q} + CW'(1);

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (bypass) begin
      lvl_d = s2_q;
      cnt_d = '0;
    end else if (s2_q == lvl_q) begin
      cnt_d = '0;
    end else if (run_len >= {1'b0, len_i}) begin
      lvl_d = s2_q;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + FLT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q  <= pin_i;
      s2_q  <= s1_q;
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign lvl_o = bypass ? s2_q : lvl_q;

  // R7: an accepted level change needs a disagreeing sample beforehand
  a_r7_change_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && $stable(len_i) && lvl_q != $past(lvl_q)) |-> (lvl_q == $past(s2_q)));
endmodule

// File: rtl/eil_detect.sv
module eil_detect
  import eil_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_i,
  input  logic [2:0] mode_i,
  input  logic       clr_i,
  input  logic       sw_i,
  output logic       stat_o
);
  logic prev_q, stat_q, stat_d, evt;

  always_comb begin
    unique case (mode_i)
      TRG_HIGH: evt = lvl_i;
      TRG_LOW:  evt = !lvl_i;
      TRG_FALL: evt = prev_q && !lvl_i;
      TRG_RISE: evt = !prev_q && lvl_i;
      TRG_BOTH: evt = prev_q != lvl_i;
      default:  evt = 1'b0;
    endcase
    stat_d = (stat_q && !clr_i) || evt || sw_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;

  a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == TRG_RISE && lvl_i && !prev_q) |=> stat_q);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !clr_i) |=> stat_q);
  a_r9_sw_sets: assert property (@(posedge clk) disable iff (!rst_n)
    sw_i |=> stat_q);
  a_r12_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i > TRG_BOTH && !sw_i && !stat_q) |=> !stat_q);
  a_r5_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == TRG_HIGH && lvl_i) |=> stat_q);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eil_pkg::*;
#(
  parameter int unsigned NLINES = 16,
  parameter int unsigned FLT_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NLINES-1:0]   pin_i,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [NLINES-1:0]   irq_o,
  output logic                wake_o
);
  localparam logic [ADDR_W-1:0] CFG_LAST = ADDR_W'(NLINES);

  logic [2:0]        mode_q [NLINES];
  logic [FLT_W-1:0]  len_q  [NLINES];
  logic [NLINES-1:0] ien_q, ien_d, wen_q, wen_d;
  logic [NLINES-1:0] stat, clr, swt, lvl;
  logic              cfg_we;

  assign cfg_we = reg_we && (reg_addr < CFG_LAST);
  assign clr    = (reg_we && reg_addr == A_STAT) ? reg_wdata[NLINES-1:0] : '0;
  assign swt    = (reg_we && reg_addr == A_SWT)  ? reg_wdata[NLINES-1:0] : '0;

  always_comb begin
    ien_d = ien_q;
    wen_d = wen_q;
    if (reg_we && reg_addr == A_IEN) ien_d = reg_wdata[NLINES-1:0];
    if (reg_we && reg_addr == A_WEN) wen_d = reg_wdata[NLINES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      wen_q <= '0;
    end else begin
      ien_q <= ien_d;
      wen_q <= wen_d;
    end
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic line_we;
    assign line_we = cfg_we && (reg_addr == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[i] <= TRG_OFF;
        len_q[i]  <= '0;
      end else if (line_we) begin
        mode_q[i] <= reg_wdata[2:0];
        len_q[i]  <= reg_wdata[8 +: FLT_W];
      end
    end

    eil_filter #(.FLT_W(FLT_W)) u_flt (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (pin_i[i]),
      .len_i (len_q[i]),
      .lvl_o (lvl[i])
    );

    eil_detect u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (lvl[i]),
      .mode_i (mode_q[i]),
      .clr_i  (clr[i]),
      .sw_i   (swt[i]),
      .stat_o (stat[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < CFG_LAST) begin
      reg_rdata[2:0]         = mode_q[reg_addr[$clog2(NLINES)-1:0]];
      reg_rdata[8 +: FLT_W]  = len_q[reg_addr[$clog2(NLINES)-1:0]];
    end else begin
      unique case (reg_addr)
        A_IEN:   reg_rdata[NLINES-1:0] = ien_q;
        A_WEN:   reg_rdata[NLINES-1:0] = wen_q;
        A_STAT:  reg_rdata[NLINES-1:0] = stat;
        default: reg_rdata = '0;
      endcase
    end
  end

  assign irq_o  = stat & ien_q;
  assign wake_o = |(stat & wen_q);

  // R10: an enabled, set flag reaches the vector once the mask is in place
  a_r10_enabled_flag_out: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_IEN && reg_wdata[0] && stat[0] && !clr[0]) |=> irq_o[0]);
  // R11: wake requires some flag
  a_r11_wake_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (stat != '0));
  // R8: a write-one clear on an idle line leaves it clear
  a_r8_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[0] && !swt[0] && mode_q[0] > TRG_BOTH) |=> !stat[0]);
endmodule

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
  localparam int NL = 16;

  typedef struct {
    int          at;
    logic [15:0] irq;
    logic        wake;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] pin;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [15:0] irq;
  logic        wake;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ext_irq_ctrl #(.NLINES(NL), .FLT_W(8)) u_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq), .wake_o(wake)
  );

  // monitor: pops scoreboard entries on their cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.at < cyc) begin
        errors++;
        $display("FAIL %s: entry for cycle %0d missed (now %0d)", e.tag, e.at, cyc);
      end else if (irq !== e.irq || wake !== e.wake) begin
        errors++;
        $display("FAIL %s: irq=%h wake=%b expected irq=%h wake=%b",
                 e.tag, irq, wake, e.irq, e.wake);
      end
    end
  end

  task automatic expect_at(int d, logic [15:0] v, logic w, string tag);
    exp_t e;
    e.at = cyc + d; e.irq = v; e.wake = w; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(logic [4:0] a, logic [31:0] exp, string tag);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s: rdata=%h expected %h", tag, reg_rdata, exp);
    end
  endtask

  task automatic direct(logic [15:0] v, logic w, string tag);
    checks++;
    if (irq !== v || wake !== w) begin
      errors++;
      $display("FAIL %s: irq=%h wake=%b expected irq=%h wake=%b", tag, irq, wake, v, w);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    settle(3);
    rst_n = 1'b1;
    settle(1);

    // R1 reset state
    direct(16'h0, 1'b0, "R1 outputs");
    rd_check(5'd18, 32'h0, "R1 status");
    rd_check(5'd0, 32'h7, "R1 cfg line0");

    wr(5'd16, 32'hFFFF);
    wr(5'd0, 32'h3);            // rising, no filter
    wr(5'd1, 32'h2);            // falling
    wr(5'd2, 32'h0);            // high level
    wr(5'd4, 32'h4);            // both edges
    wr(5'd5, 32'h0403);         // rising, filter 4
    wr(5'd6, 32'h3);            // rising
    wr(5'd7, 32'h6);            // off
    pin[3] = 1'b1;
    settle(4);
    wr(5'd3, 32'h1);            // low level, pin idle high
    expect_at(2, 16'h0, 1'b0, "R6 idle high quiet");
    settle(4);

    // R2 rising edge, bypassed filter
    pin[0] = 1'b1;
    expect_at(2, 16'h0, 1'b0, "R2 not early");
    expect_at(3, 16'h1, 1'b0, "R2 rise latency");
    settle(5);
    wr(5'd18, 32'h0);
    expect_at(1, 16'h1, 1'b0, "R8 write zero keeps");
    settle(2);
    wr(5'd18, 32'h1);
    expect_at(1, 16'h0, 1'b0, "R8 clear");
    expect_at(3, 16'h0, 1'b0, "R2 held high no refire");
    settle(4);
    pin[0] = 1'b0;
    expect_at(5, 16'h0, 1'b0, "R2 fall ignored");
    settle(7);

    // R3 falling
    pin[1] = 1'b1;
    expect_at(5, 16'h0, 1'b0, "R3 rise ignored");
    settle(6);
    pin[1] = 1'b0;
    expect_at(2, 16'h0, 1'b0, "R3 not early");
    expect_at(3, 16'h2, 1'b0, "R3 fall latency");
    settle(4);
    wr(5'd18, 32'h2);
    settle(2);

    // R5 high level against clear
    pin[2] = 1'b1;
    expect_at(3, 16'h4, 1'b0, "R5 level sets");
    settle(4);
    wr(5'd18, 32'h4);
    expect_at(1, 16'h4, 1'b0, "R5 clear while active");
    settle(2);
    pin[2] = 1'b0;
    settle(4);
    wr(5'd18, 32'h4);
    expect_at(1, 16'h0, 1'b0, "R5 clear after release");
    settle(2);

    // R6 low level
    pin[3] = 1'b0;
    expect_at(3, 16'h8, 1'b0, "R6 low sets");
    settle(4);
    pin[3] = 1'b1;
    settle(4);
    wr(5'd18, 32'h8);
    expect_at(1, 16'h0, 1'b0, "R6 cleared");
    settle(2);

    // R4 both edges
    pin[4] = 1'b1;
    expect_at(3, 16'h10, 1'b0, "R4 rise");
    settle(4);
    wr(5'd18, 32'h10);
    settle(2);
    pin[4] = 1'b0;
    expect_at(3, 16'h10, 1'b0, "R4 fall");
    settle(4);
    wr(5'd18, 32'h10);
    expect_at(1, 16'h0, 1'b0, "R4 cleared");
    settle(2);

    // R7 filter length 4
    pin[5] = 1'b1;
    expect_at(8, 16'h0, 1'b0, "R7 short pulse rejected");
    settle(3);
    pin[5] = 1'b0;
    settle(10);
    pin[5] = 1'b1;
    expect_at(6, 16'h0, 1'b0, "R7 not early");
    expect_at(7, 16'h20, 1'b0, "R7 exact length accepted");
    settle(4);
    pin[5] = 1'b0;
    settle(6);
    wr(5'd18, 32'h20);
    expect_at(1, 16'h0, 1'b0, "R7 cleared");
    settle(8);

    // R10 / R11 masking and wake
    wr(5'd16, 32'hFFBF);
    wr(5'd17, 32'h40);
    pin[6] = 1'b1;
    expect_at(3, 16'h0, 1'b1, "R10 masked, R11 wake");
    settle(5);
    rd_check(5'd18, 32'h40, "R10 masked flag readable");
    wr(5'd16, 32'hFFFF);
    expect_at(1, 16'h40, 1'b1, "R10 unmask");
    settle(2);
    wr(5'd17, 32'h0);
    expect_at(1, 16'h40, 1'b0, "R11 wake disabled");
    settle(2);
    wr(5'd18, 32'h40);
    pin[6] = 1'b0;
    settle(4);

    // R12 off line
    pin[7] = 1'b1;
    settle(3);
    pin[7] = 1'b0;
    expect_at(5, 16'h0, 1'b0, "R12 off line quiet");
    settle(7);
    rd_check(5'd18, 32'h0, "R12 status");

    // R9 software trigger on off line
    wr(5'd19, 32'h200);
    expect_at(1, 16'h200, 1'b0, "R9 soft trigger");
    settle(2);
    rd_check(5'd19, 32'h0, "R9 reads zero");
    wr(5'd17, 32'h200);
    expect_at(1, 16'h200, 1'b1, "R11 wake from soft flag");
    settle(2);
    wr(5'd18, 32'h200);
    expect_at(1, 16'h0, 1'b0, "R11 wake drops");
    settle(3);

    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d entries left, expected 0", q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule